// File: doc/BRIEF.md
# Runahead Mode Entry and Exit Controller

This controller sits beside the fetch and issue logic of a simple in-order pipeline. It takes that pipeline into runahead operation and brings it back out. On a cache miss the pipeline does not stall. The controller saves the address of the missing instruction and sends a checkpoint strobe, so the register file is copied into its shadow copy. The pipeline then keeps executing speculatively past the miss. When the memory system reports that the miss has been serviced, the controller sends three things in one cycle: a restore strobe, a global clear of the per-register invalid flags, and a fetch redirect back to the saved address. All results produced during the episode are therefore thrown away. The episode has only served to warm the caches.

While an episode is running, the controller also decides what happens to control transfers whose operands are marked invalid. One configuration input picks between two policies, and its value is captured when the episode starts. The conservative policy freezes the pipeline until the miss returns. The aggressive policy keeps going: it uses the branch predictor's direction for conditional branches, and the top of the return stack for returns. An indirect jump whose target register is invalid still freezes the pipeline under either policy. The datapath, the caches and the predictor are outside the block and appear only as ports.

Top module: `ra_mode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, before any miss arrives, every strobe (`ckpt_o`, `restore_o`, `inv_clear_o`, `redirect_valid_o`, `dir_valid_o`, `jmp_valid_o`) is low, and `runahead_o` and `stall_o` are low.
- R2: In normal operation, a data-cache miss (`dmiss_i`) makes `ckpt_o` high for exactly the next cycle. From that cycle on, `runahead_o` is high. No fetch redirect is issued.
- R3: In normal operation, an instruction-cache miss (`imiss_i`) makes `ckpt_o` high in the next cycle. In that same cycle `redirect_valid_o` is high and `redirect_pc_o` holds the start of the next sequential cache line: `miss_pc_i` with its low log2(LINE_BYTES) bits cleared, plus LINE_BYTES (32 by default).
- R4: During an episode, `done_i` causes the following to happen together in the next cycle, for one cycle only: `restore_o`, `inv_clear_o` and `redirect_valid_o` go high, and `redirect_pc_o` equals the `miss_pc_i` captured at entry. `runahead_o` is low in that same cycle.
- R5: A miss that arrives while an episode is running produces no `ckpt_o` and no redirect. It does not change the address restored at exit.
- R6: Outside an episode, branch and jump resolution ignores the invalid flags. `dir_taken_o` follows `br_taken_i` and `jmp_pc_o` follows `jmp_tgt_i`, both with `dir_valid_o` / `jmp_valid_o` high one cycle after the request.
- R7: Under the aggressive policy during an episode, a conditional branch whose condition is flagged invalid gets `dir_valid_o` high, with `dir_taken_o` equal to `br_pred_i`.
- R8: Under the aggressive policy during an episode, an indirect jump that is flagged invalid and marked as a return (`jmp_ret_i`) gets `jmp_valid_o` high, with `jmp_pc_o` equal to `ras_top_i`.
- R9: During an episode, an invalid non-return indirect jump sets `stall_o` high from the next cycle until the exit cycle, where it is low. While `stall_o` is high, no direction or jump output is given.
- R10: Under the conservative policy during an episode, any conditional branch or indirect jump flagged invalid gives no direction or jump output and raises `stall_o` from the next cycle until exit.
- R11: `policy_aggr_i` (1 = aggressive, 0 = conservative) is sampled in the cycle the episode starts. Changes to it during the episode have no effect until the next entry.
- R12: During an episode, branches and jumps whose operands are valid resolve from `br_taken_i` / `jmp_tgt_i` exactly as in normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imiss_i | input | 1 | Instruction-cache miss |
| dmiss_i | input | 1 | Data-cache miss |
| miss_pc_i | input | PC_W | PC of the instruction that missed |
| done_i | input | 1 | Outstanding miss has been serviced |
| policy_aggr_i | input | 1 | Branch policy: 1 aggressive, 0 conservative |
| br_valid_i | input | 1 | Conditional branch being resolved |
| br_inv_i | input | 1 | Branch condition flagged invalid |
| br_taken_i | input | 1 | Computed branch outcome |
| br_pred_i | input | 1 | Predictor direction |
| jmp_valid_i | input | 1 | Indirect jump being resolved |
| jmp_inv_i | input | 1 | Jump target register flagged invalid |
| jmp_ret_i | input | 1 | Jump is a subroutine return |
| jmp_tgt_i | input | PC_W | Computed jump target |
| ras_top_i | input | PC_W | Top of return stack |
| ckpt_o | output | 1 | Copy register file to backup |
| restore_o | output | 1 | Copy backup to register file |
| inv_clear_o | output | 1 | Clear all invalid flags |
| redirect_valid_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | PC_W | Fetch redirect target |
| dir_valid_o | output | 1 | Branch direction available |
| dir_taken_o | output | 1 | Branch direction |
| jmp_valid_o | output | 1 | Jump target available |
| jmp_pc_o | output | PC_W | Jump target |
| stall_o | output | 1 | Pipeline stall request |
| runahead_o | output | 1 | Episode in progress; results are speculative |

## Verification
The bench sends a second miss into a running episode with a different PC. A design that re-armed on that miss would pulse a checkpoint, or would return to the wrong instruction at exit. It changes the policy input in the middle of an episode, which exposes a controller that reads the live input instead of the captured value. It uses an instruction-cache miss PC that is not line-aligned, so a missing mask or a wrong line step shows up as a bad redirect target. The exit cycle is checked for the restore, the invalid-flag clear and the redirect all arriving together with the mode flag dropping, and for the stall being released; a design that staggers these would let speculative work retire after rollback. Invalid flags presented outside an episode check that normal resolution is never diverted to the predictor or the return stack.

// File: rtl/ra_pkg.sv
package ra_pkg;

    typedef enum logic [1:0] {
        RA_NORMAL = 2'd0,
        RA_RUN    = 2'd1,
        RA_HOLD   = 2'd2
    } ra_state_e;

endpackage

// File: rtl/ra_br_resolve.sv
// Decides how a control transfer is resolved, given the current mode,
// the captured policy and the invalid flags of its operands.
module ra_br_resolve #(
    parameter int PC_W = 32
) (
    input  logic            in_ra,
    input  logic            aggr,
    input  logic            br_v,
    input  logic            br_inv,
    input  logic            br_taken,
    input  logic            br_pred,
    input  logic            jv_in,
    input  logic            j_inv,
    input  logic            j_ret,
    input  logic [PC_W-1:0] j_tgt,
    input  logic [PC_W-1:0] ras_top,
    output logic            dir_v,
    output logic            dir_t,
    output logic            jv_out,
    output logic [PC_W-1:0] jpc,
    output logic            hold_req
);

    logic br_spec;
    logic j_spec;
    logic j_spec_ok;
    logic br_block;
    logic j_block;

    always_comb begin
        br_spec   = in_ra && br_inv;
        j_spec    = in_ra && j_inv;
        j_spec_ok = aggr && j_ret;
        br_block  = br_v && br_spec && !aggr;
        j_block   = jv_in && j_spec && !j_spec_ok;
        hold_req  = br_block || j_block;
        dir_v     = br_v && !br_block && !hold_req;
        dir_t     = br_spec ? br_pred : br_taken;
        jv_out    = jv_in && !j_block && !hold_req;
        jpc       = j_spec ? ras_top : j_tgt;
    end

endmodule

// File: rtl/ra_line_step.sv
// Address of the first instruction of the next sequential cache line.
module ra_line_step #(
    parameter int PC_W       = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] next_line
);

    localparam int OFF_W = $clog2(LINE_BYTES);

    generate
        if (OFF_W == 0) begin : g_unit
            assign next_line = pc + PC_W'(1);
        end else begin : g_line
            logic [PC_W-1:0] base;
            assign base      = {pc[PC_W-1:OFF_W], {OFF_W{1'b0}}};
            assign next_line = base + PC_W'(LINE_BYTES);
        end
    endgenerate

endmodule

// File: rtl/ra_mode_ctrl.sv
module ra_mode_ctrl
    import ra_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            imiss_i,
    input  logic            dmiss_i,
    input  logic [PC_W-1:0] miss_pc_i,
    input  logic            done_i,
    input  logic            policy_aggr_i,
    input  logic            br_valid_i,
    input  logic            br_inv_i,
    input  logic            br_taken_i,
    input  logic            br_pred_i,
    input  logic            jmp_valid_i,
    input  logic            jmp_inv_i,
    input  logic            jmp_ret_i,
    input  logic [PC_W-1:0] jmp_tgt_i,
    input  logic [PC_W-1:0] ras_top_i,
    output logic            ckpt_o,
    output logic            restore_o,
    output logic            inv_clear_o,
    output logic            redirect_valid_o,
    output logic [PC_W-1:0] redirect_pc_o,
    output logic            dir_valid_o,
    output logic            dir_taken_o,
    output logic            jmp_valid_o,
    output logic [PC_W-1:0] jmp_pc_o,
    output logic            stall_o,
    output logic            runahead_o
);

    typedef struct packed {
        ra_state_e       st;
        logic            aggr;
        logic [PC_W-1:0] spc;
        logic            ckpt;
        logic            rest;
        logic            clr;
        logic            rv;
        logic [PC_W-1:0] rpc;
        logic            dv;
        logic            dt;
        logic            jv;
        logic [PC_W-1:0] jpc;
    } ctrl_t;

    ctrl_t r_q, r_d;

    logic            res_dv, res_dt, res_jv, res_hold;
    logic [PC_W-1:0] res_jpc;
    logic [PC_W-1:0] line_pc;
    logic            in_ra;

    assign in_ra = (r_q.st != RA_NORMAL);

    ra_br_resolve #(.PC_W(PC_W)) u_res (
        .in_ra    (in_ra),
        .aggr     (r_q.aggr),
        .br_v     (br_valid_i),
        .br_inv   (br_inv_i),
        .br_taken (br_taken_i),
        .br_pred  (br_pred_i),
        .jv_in    (jmp_valid_i),
        .j_inv    (jmp_inv_i),
        .j_ret    (jmp_ret_i),
        .j_tgt    (jmp_tgt_i),
        .ras_top  (ras_top_i),
        .dir_v    (res_dv),
        .dir_t    (res_dt),
        .jv_out   (res_jv),
        .jpc      (res_jpc),
        .hold_req (res_hold)
    );

    ra_line_step #(.PC_W(PC_W), .LINE_BYTES(LINE_BYTES)) u_line (
        .pc        (miss_pc_i),
        .next_line (line_pc)
    );

    always_comb begin
        r_d      = r_q;
        r_d.ckpt = 1'b0;
        r_d.rest = 1'b0;
        r_d.clr  = 1'b0;
        r_d.rv   = 1'b0;
        r_d.dv   = 1'b0;
        r_d.jv   = 1'b0;
        r_d.dt   = res_dt;
        r_d.jpc  = res_jpc;
        unique case (r_q.st)
            RA_NORMAL: begin
                r_d.dv = res_dv;
                r_d.jv = res_jv;
                if (imiss_i || dmiss_i) begin
                    r_d.st   = RA_RUN;
                    r_d.aggr = policy_aggr_i;
                    r_d.spc  = miss_pc_i;
                    r_d.ckpt = 1'b1;
                    if (imiss_i) begin
                        r_d.rv  = 1'b1;
                        r_d.rpc = line_pc;
                    end
                end
            end
            RA_RUN: begin
                if (done_i) begin
                    r_d.st   = RA_NORMAL;
                    r_d.rest = 1'b1;
                    r_d.clr  = 1'b1;
                    r_d.rv   = 1'b1;
                    r_d.rpc  = r_q.spc;
                end else if (res_hold) begin
                    r_d.st = RA_HOLD;
                end else begin
                    r_d.dv = res_dv;
                    r_d.jv = res_jv;
                end
            end
            RA_HOLD: begin
                if (done_i) begin
                    r_d.st   = RA_NORMAL;
                    r_d.rest = 1'b1;
                    r_d.clr  = 1'b1;
                    r_d.rv   = 1'b1;
                    r_d.rpc  = r_q.spc;
                end
            end
            default: r_d.st = RA_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ckpt_o           = r_q.ckpt;
    assign restore_o        = r_q.rest;
    assign inv_clear_o      = r_q.clr;
    assign redirect_valid_o = r_q.rv;
    assign redirect_pc_o    = r_q.rpc;
    assign dir_valid_o      = r_q.dv;
    assign dir_taken_o      = r_q.dt;
    assign jmp_valid_o      = r_q.jv;
    assign jmp_pc_o         = r_q.jpc;
    assign stall_o          = (r_q.st == RA_HOLD);
    assign runahead_o       = in_ra;

endmodule

// File: rtl/ra_mode_ctrl_chk.sv
module ra_mode_ctrl_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] miss_pc_i,
    input logic            ckpt_o,
    input logic            restore_o,
    input logic            inv_clear_o,
    input logic            redirect_valid_o,
    input logic [PC_W-1:0] redirect_pc_o,
    input logic            dir_valid_o,
    input logic            jmp_valid_o,
    input logic            stall_o,
    input logic            runahead_o,
    input logic            pol_q
);

    logic [PC_W-1:0] pc_prev_q;
    logic [PC_W-1:0] saved_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_prev_q <= '0;
            saved_q   <= '0;
        end else begin
            pc_prev_q <= miss_pc_i;
            if (ckpt_o) saved_q <= pc_prev_q;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !ckpt_o && !restore_o && !runahead_o && !stall_o);

    // R2
    entry_ckpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(runahead_o) |-> ckpt_o);

    // R4
    exit_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_o |-> inv_clear_o && redirect_valid_o && !runahead_o && !stall_o);

    // R4
    exit_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_o |-> redirect_pc_o == saved_q);

    // R5
    no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        runahead_o && $past(runahead_o) |-> !ckpt_o);

    // R9
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> runahead_o && !dir_valid_o && !jmp_valid_o);

    // R11
    policy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        runahead_o && $past(runahead_o) |-> $stable(pol_q));

endmodule

bind ra_mode_ctrl ra_mode_ctrl_chk #(.PC_W(PC_W)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .miss_pc_i        (miss_pc_i),
    .ckpt_o           (ckpt_o),
    .restore_o        (restore_o),
    .inv_clear_o      (inv_clear_o),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o),
    .dir_valid_o      (dir_valid_o),
    .jmp_valid_o      (jmp_valid_o),
    .stall_o          (stall_o),
    .runahead_o       (runahead_o),
    .pol_q            (r_q.aggr)
);

// File: tb/ra_mode_ctrl_tb.sv
module ra_mode_ctrl_tb_top;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            imiss_i, dmiss_i, done_i, policy_aggr_i;
    logic [PC_W-1:0] miss_pc_i, jmp_tgt_i, ras_top_i;
    logic            br_valid_i, br_inv_i, br_taken_i, br_pred_i;
    logic            jmp_valid_i, jmp_inv_i, jmp_ret_i;
    logic            ckpt_o, restore_o, inv_clear_o, redirect_valid_o;
    logic [PC_W-1:0] redirect_pc_o, jmp_pc_o;
    logic            dir_valid_o, dir_taken_o, jmp_valid_o, stall_o, runahead_o;

    int checks = 0;
    int fails  = 0;
    bit done_all = 1'b0;

    always #4 clk = ~clk;

    ra_mode_ctrl #(.PC_W(PC_W), .LINE_BYTES(32)) dut_i (.*);

    task automatic chk(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle;
        imiss_i = 0; dmiss_i = 0; done_i = 0;
        br_valid_i = 0; br_inv_i = 0; br_taken_i = 0; br_pred_i = 0;
        jmp_valid_i = 0; jmp_inv_i = 0; jmp_ret_i = 0;
    endtask

    task automatic tick;
        @(posedge clk); #2;
    endtask

    task automatic enter(input bit aggr, input logic [PC_W-1:0] pc);
        @(negedge clk); idle(); dmiss_i = 1; miss_pc_i = pc; policy_aggr_i = aggr;
        tick();
        @(negedge clk); idle();
    endtask

    task automatic leave(input logic [PC_W-1:0] pc);
        @(negedge clk); idle(); done_i = 1;
        tick();
        chk("R4 restore", restore_o, 1);
        chk("R4 clear", inv_clear_o, 1);
        chk("R4 redirect", redirect_valid_o, 1);
        chk("R4 pc", redirect_pc_o, pc);
        chk("R4 mode", runahead_o, 0);
        chk("R9 stall released", stall_o, 0);
        @(negedge clk); idle();
        tick();
        chk("R4 one-cycle", restore_o, 0);
    endtask

    task automatic t_reset;
        rst_n = 0; idle(); policy_aggr_i = 0; miss_pc_i = 0; jmp_tgt_i = 0; ras_top_i = 0;
        repeat (3) tick();
        chk("R1 ckpt", ckpt_o, 0);
        chk("R1 mode", runahead_o, 0);
        @(negedge clk); rst_n = 1;
        tick();
        chk("R1 strobes", {ckpt_o, restore_o, inv_clear_o, redirect_valid_o, dir_valid_o, jmp_valid_o, stall_o}, 0);
    endtask

    task automatic t_dmiss;
        @(negedge clk); idle(); dmiss_i = 1; miss_pc_i = 32'h1000_0044; policy_aggr_i = 0;
        tick();
        chk("R2 ckpt", ckpt_o, 1);
        chk("R2 mode", runahead_o, 1);
        chk("R2 no redirect", redirect_valid_o, 0);
        @(negedge clk); idle();
        tick();
        chk("R2 ckpt pulse", ckpt_o, 0);
        leave(32'h1000_0044);
    endtask

    task automatic t_imiss;
        @(negedge clk); idle(); imiss_i = 1; miss_pc_i = 32'h0000_2A37; policy_aggr_i = 1;
        tick();
        chk("R3 ckpt", ckpt_o, 1);
        chk("R3 redirect", redirect_valid_o, 1);
        chk("R3 line", redirect_pc_o, 32'h0000_2A40);
        @(negedge clk); idle(); dmiss_i = 1; imiss_i = 1; miss_pc_i = 32'h0000_5555;
        tick();
        chk("R5 no ckpt", ckpt_o, 0);
        chk("R5 no redirect", redirect_valid_o, 0);
        leave(32'h0000_2A37);
    endtask

    task automatic t_normal_br;
        @(negedge clk); idle();
        br_valid_i = 1; br_inv_i = 1; br_taken_i = 1; br_pred_i = 0;
        jmp_valid_i = 1; jmp_inv_i = 1; jmp_ret_i = 1; jmp_tgt_i = 32'h300; ras_top_i = 32'h900;
        tick();
        chk("R6 dir valid", dir_valid_o, 1);
        chk("R6 dir", dir_taken_o, 1);
        chk("R6 jmp valid", jmp_valid_o, 1);
        chk("R6 jmp pc", jmp_pc_o, 32'h300);
        chk("R6 no stall", stall_o, 0);
    endtask

    task automatic t_aggr;
        enter(1, 32'h0000_8000);
        @(negedge clk); idle(); br_valid_i = 1; br_inv_i = 1; br_taken_i = 0; br_pred_i = 1;
        tick();
        chk("R7 dir valid", dir_valid_o, 1);
        chk("R7 dir", dir_taken_o, 1);
        @(negedge clk); idle(); br_valid_i = 1; br_inv_i = 0; br_taken_i = 0; br_pred_i = 1;
        tick();
        chk("R12 dir valid", dir_valid_o, 1);
        chk("R12 dir", dir_taken_o, 0);
        @(negedge clk); idle(); jmp_valid_i = 1; jmp_inv_i = 1; jmp_ret_i = 1;
        jmp_tgt_i = 32'h444; ras_top_i = 32'h777;
        tick();
        chk("R8 jmp valid", jmp_valid_o, 1);
        chk("R8 jmp pc", jmp_pc_o, 32'h777);
        @(negedge clk); idle(); jmp_valid_i = 1; jmp_inv_i = 0; jmp_tgt_i = 32'h444;
        tick();
        chk("R12 jmp pc", jmp_pc_o, 32'h444);
        @(negedge clk); idle(); jmp_valid_i = 1; jmp_inv_i = 1; jmp_ret_i = 0;
        tick();
        chk("R9 stall", stall_o, 1);
        chk("R9 no jmp", jmp_valid_o, 0);
        @(negedge clk); idle(); br_valid_i = 1;
        tick();
        chk("R9 stall held", stall_o, 1);
        chk("R9 no dir", dir_valid_o, 0);
        leave(32'h0000_8000);
    endtask

    task automatic t_cons;
        enter(0, 32'h0000_9100);
        @(negedge clk); idle(); jmp_valid_i = 1; jmp_inv_i = 1; jmp_ret_i = 1; ras_top_i = 32'h123;
        tick();
        chk("R10 jmp stall", stall_o, 1);
        chk("R10 no jmp", jmp_valid_o, 0);
        leave(32'h0000_9100);
        enter(0, 32'h0000_9200);
        @(negedge clk); idle(); br_valid_i = 1; br_inv_i = 1; br_pred_i = 1;
        tick();
        chk("R10 br stall", stall_o, 1);
        chk("R10 no dir", dir_valid_o, 0);
        leave(32'h0000_9200);
    endtask

    task automatic t_policy;
        enter(1, 32'h0000_A000);
        @(negedge clk); idle(); policy_aggr_i = 0; br_valid_i = 1; br_inv_i = 1; br_pred_i = 1;
        tick();
        chk("R11 aggr kept", dir_valid_o, 1);
        chk("R11 no stall", stall_o, 0);
        leave(32'h0000_A000);
        enter(0, 32'h0000_B000);
        @(negedge clk); idle(); policy_aggr_i = 1; br_valid_i = 1; br_inv_i = 1; br_pred_i = 1;
        tick();
        chk("R11 cons kept", stall_o, 1);
        leave(32'h0000_B000);
    endtask

    initial begin
        t_reset();
        t_dmiss();
        t_imiss();
        t_normal_br();
        t_aggr();
        t_cons();
        t_policy();
        done_all = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_all) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule